// File: doc/BRIEF.md
# Two-Level Page Table Walker with Page Memory Types

This block resolves one 32-bit virtual address at a time through a two-level page table and returns either a physical address or a page fault. It is meant to sit behind a core's translation miss path. The block holds the request fields while it walks the table and issues at most one 32-bit table read at a time over a request/response port.

Each walk has a stage selector and two enable bits, one at machine level and one at hypervisor level. Together these decide how the top two bits of the final leaf entry are used. When memory types are on for the stage, those bits leave the block as a 2-bit memory-type attribute, and the physical address is limited to 32 bits. When memory types are off, the same bits become physical address bits 33:32, and the attribute reads zero.

Leaves can appear at either level, so the block handles 4 KiB pages and 4 MiB superpages. A single-cycle `done` pulse carries the result.

Top module: `sv32w_walker`

## Requirements
- R1: While `rst_n` is low and after reset, `done` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: The first table read goes to `root_ppn*4096 + va[31:22]*4`. After a pointer entry at level 1 (V=1, R=0, W=0, X=0), the second read goes to `pte[31:10]*4096 + va[21:12]*4`. While `mem_req_valid` is high and `mem_req_ready` is low, the read address is held.
- R3: A level-0 leaf with memory types on gives the address `{2'b00, pte[29:10], va[11:0]}` and an attribute equal to `pte[31:30]`.
- R4: With memory types off, any leaf puts `pte[31:30]` on physical address bits 33:32, and the attribute is 0.
- R5: A level-1 leaf gives the address `{hi, pte[29:20], va[21:0]}`, where `hi` is 00 when memory types are on and `pte[31:30]` when they are off. If `pte[19:10]` is nonzero, the walk faults instead.
- R6: The stage code is 0 for S, 1 for G, and 2 or 3 for VS. Stages 0 and 1 use the machine enable alone. Stages 2 and 3 use the hypervisor enable ANDed with the machine enable.
- R7: The walk faults on an entry with V=0, on an entry with W=1 and R=0, and on a pointer entry found at level 0.
- R8: With memory types on, the walk faults on a leaf with `pte[31:30]`=3 and on a pointer entry with nonzero `pte[31:30]`. With memory types off, neither case faults.
- R9: `done` lasts exactly one cycle. A faulting walk returns address 0 and attribute 0. `req_ready` is high only while the block is idle.
- R10: A request raised during the `done` cycle is not taken in that cycle. It is taken on the next cycle and walked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle; request taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_stage | input | 2 | 0 = S, 1 = G, 2/3 = VS |
| req_root_ppn | input | 22 | Root table page number |
| menv_mt_en | input | 1 | Machine-level memory-type enable |
| henv_mt_en | input | 1 | Hypervisor-level memory-type enable |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | 34 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk ended in a page fault |
| done_paddr | output | 34 | Translated physical address |
| done_mtype | output | 2 | Memory-type attribute |

## Verification
The result strobe of one walk and the arrival of the next request can fall in the same cycle. The bench raises each new request on the falling edge where it first sees `done` high. It then checks three things: `req_ready` is low at that moment, exactly one further cycle passes before the request is taken, and the first read address belongs to the new request. Because every table vector follows the previous one this way, the overlap is exercised across all walk shapes, including faults and superpages.

// File: rtl/sv32w_pkg.sv
// Shared sizes and types for the page table walker.
// Assumes a two-level table, 4 KiB pages and 32-bit entries.
package sv32w_pkg;
    localparam int VA_W     = 32;
    localparam int PTE_W    = 32;
    localparam int PA_W     = 34;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int PPN_W    = PTE_W - IDX_W;   // 22-bit page number in an entry
    localparam int MT_W     = 2;
    localparam int ENTRY_SH = 2;               // 4-byte entries

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_L1,
        ST_WAIT_L1,
        ST_READ_L0,
        ST_WAIT_L0,
        ST_DONE
    } walk_state_t;
endpackage

// File: rtl/sv32w_mt_enable.sv
// Resolves whether memory types apply to a request's stage.
// Assumes stage codes 0 = S, 1 = G, 2 and 3 = VS. The hypervisor bit is
// gated by the machine bit, because it reads as zero when that bit is clear.
module sv32w_mt_enable (
    input  logic [1:0] stage,
    input  logic       m_en,
    input  logic       h_en,
    output logic       mt_on
);
    logic h_eff;

    // Effective hypervisor enable after gating by the machine enable.
    always_comb h_eff = h_en & m_en;

    // Select the enable that governs the stage.
    always_comb mt_on = stage[1] ? h_eff : m_en;
endmodule

// File: rtl/sv32w_pte_check.sv
// Classifies one table entry: leaf, pointer, or fault.
// Assumes level 1 is the first table read and level 0 the last.
module sv32w_pte_check
    import sv32w_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             at_l0,
    input  logic             mt_on,
    output logic             is_leaf,
    output logic             fault,
    output logic [PPN_W-1:0] next_ppn
);
    logic v, r, w, x;
    logic [MT_W-1:0] top;
    logic f_basic, f_level, f_type;
    logic [5:0] unused_flags;

    // Split out the flag bits and the top attribute bits.
    always_comb begin
        v            = pte[0];
        r            = pte[1];
        w            = pte[2];
        x            = pte[3];
        top          = pte[PTE_W-1 -: MT_W];
        unused_flags = pte[9:4];
        next_ppn     = pte[PTE_W-1:IDX_W];
    end

    // A valid entry with read or execute permission is a leaf.
    always_comb is_leaf = v & (r | x);

    // Fault conditions grouped by cause.
    always_comb begin
        f_basic = ~v | (w & ~r);
        f_level = (~is_leaf & at_l0) |
                  (is_leaf & ~at_l0 & (pte[IDX_W +: IDX_W] != '0));
        f_type  = mt_on & ((is_leaf & (top == 2'b11)) |
                           (~is_leaf & (top != 2'b00)));
        fault   = f_basic | f_level | f_type;
    end
endmodule

// File: rtl/sv32w_pa_build.sv
// Forms the physical address and the memory-type attribute from a leaf entry.
// Assumes the entry has already been accepted as a fault-free leaf.
module sv32w_pa_build
    import sv32w_pkg::*;
(
    input  logic [PTE_W-1:0]       pte,
    input  logic [OFF_W+IDX_W-1:0] va_low,
    input  logic                   at_l0,
    input  logic                   mt_on,
    output logic [PA_W-1:0]        paddr,
    output logic [MT_W-1:0]        mtype
);
    logic [MT_W-1:0] hi;

    // The top entry bits are either extra address bits or the attribute.
    always_comb begin
        hi    = mt_on ? '0 : pte[PTE_W-1 -: MT_W];
        mtype = mt_on ? pte[PTE_W-1 -: MT_W] : '0;
    end

    // A superpage keeps the lower virtual index; a 4 KiB page replaces it.
    always_comb begin
        if (at_l0)
            paddr = {hi, pte[PTE_W-MT_W-1:IDX_W], va_low[OFF_W-1:0]};
        else
            paddr = {hi, pte[PTE_W-MT_W-1:2*IDX_W], va_low};
    end
endmodule

// File: rtl/sv32w_walker.sv
// Two-level page table walker with per-stage memory-type attribute.
// Takes one request while idle and keeps one table read outstanding.
// Ends each walk with a one-cycle done pulse.
// Assumes the memory port returns exactly one response per accepted read.
module sv32w_walker
    import sv32w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_stage,
    input  logic [PPN_W-1:0]  req_root_ppn,
    input  logic              menv_mt_en,
    input  logic              henv_mt_en,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              done_fault,
    output logic [PA_W-1:0]   done_paddr,
    output logic [MT_W-1:0]   done_mtype
);
    localparam int VLOW_W = OFF_W + IDX_W;

    walk_state_t            state;
    logic [VLOW_W-1:0]      va_q;
    logic                   mt_on_q;
    logic [PA_W-1:0]        rd_addr_q;
    logic                   fault_q;
    logic [PA_W-1:0]        paddr_q;
    logic [MT_W-1:0]        mtype_q;

    logic                   mt_on_req;
    logic                   at_l0;
    logic                   chk_leaf;
    logic                   chk_fault;
    logic [PPN_W-1:0]       chk_next;
    logic [PA_W-1:0]        pa_new;
    logic [MT_W-1:0]        mt_new;
    logic [PA_W-1:0]        root_addr;
    logic [PA_W-1:0]        l0_addr;

    sv32w_mt_enable u_en (
        .stage (req_stage),
        .m_en  (menv_mt_en),
        .h_en  (henv_mt_en),
        .mt_on (mt_on_req)
    );

    sv32w_pte_check u_chk (
        .pte      (mem_rsp_data),
        .at_l0    (at_l0),
        .mt_on    (mt_on_q),
        .is_leaf  (chk_leaf),
        .fault    (chk_fault),
        .next_ppn (chk_next)
    );

    sv32w_pa_build u_pa (
        .pte    (mem_rsp_data),
        .va_low (va_q),
        .at_l0  (at_l0),
        .mt_on  (mt_on_q),
        .paddr  (pa_new),
        .mtype  (mt_new)
    );

    // Level of the entry now being returned.
    always_comb at_l0 = (state == ST_WAIT_L0);

    // Entry addresses for the root table and the second-level table.
    always_comb begin
        root_addr = {req_root_ppn, {OFF_W{1'b0}}} +
                    PA_W'({req_vaddr[VA_W-1 -: IDX_W], {ENTRY_SH{1'b0}}});
        l0_addr   = {chk_next, {OFF_W{1'b0}}} +
                    PA_W'({va_q[VLOW_W-1 -: IDX_W], {ENTRY_SH{1'b0}}});
    end

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            mt_on_q   <= 1'b0;
            rd_addr_q <= '0;
            fault_q   <= 1'b0;
            paddr_q   <= '0;
            mtype_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q      <= req_vaddr[VLOW_W-1:0];
                        mt_on_q   <= mt_on_req;
                        rd_addr_q <= root_addr;
                        state     <= ST_READ_L1;
                    end
                end
                ST_READ_L1, ST_READ_L0: begin
                    if (mem_req_ready)
                        state <= (state == ST_READ_L1) ? ST_WAIT_L1 : ST_WAIT_L0;
                end
                ST_WAIT_L1, ST_WAIT_L0: begin
                    if (mem_rsp_valid) begin
                        if (chk_fault) begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            mtype_q <= '0;
                            state   <= ST_DONE;
                        end else if (chk_leaf) begin
                            fault_q <= 1'b0;
                            paddr_q <= pa_new;
                            mtype_q <= mt_new;
                            state   <= ST_DONE;
                        end else begin
                            rd_addr_q <= l0_addr;
                            state     <= ST_READ_L0;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port views of the state.
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_READ_L1) || (state == ST_READ_L0);
        mem_req_addr  = rd_addr_q;
        done          = (state == ST_DONE);
        done_fault    = fault_q;
        done_paddr    = paddr_q;
        done_mtype    = mtype_q;
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !done));

    a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r4_mt_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mt_on_q) |-> (done_mtype == 2'b00));

    a_r3_mt_on_short_pa: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault && mt_on_q) |-> (done_paddr[PA_W-1 -: MT_W] == 2'b00));

    a_r8_no_reserved_type: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (done_mtype != 2'b11));

    a_r9_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_paddr == '0 && done_mtype == '0));
endmodule

// File: tb/sv32w_walker_test.sv
`timescale 1ns/1ps
module sv32w_walker_test;
    typedef struct packed {
        logic [1:0]  stage;
        logic        men;
        logic        hen;
        logic [31:0] va;
        logic [21:0] root;
        logic [31:0] pte1;
        logic [31:0] pte0;
        logic        fault;
        logic [33:0] pa;
        logic [1:0]  mt;
        logic [1:0]  nrd;
    } vec_t;

    localparam int NV = 17;
    localparam logic [31:0] VA = 32'h1234_5678;
    localparam logic [21:0] RT = 22'h00100;
    // R3 R4 R5 R6 R7 R8 tags are given per row.
    localparam vec_t VT [NV] = '{
        '{2'd0,1'b1,1'b0,VA,RT,32'h0008_0001,32'hAAF3_78CF,1'b0,34'h0_ABCD_E678,2'd2,2'd2}, // R3
        '{2'd0,1'b0,1'b0,VA,RT,32'h0008_0001,32'hAAF3_78CF,1'b0,34'h2_ABCD_E678,2'd0,2'd2}, // R4
        '{2'd2,1'b1,1'b1,VA,RT,32'h0008_0001,32'hAAF3_78CF,1'b0,34'h0_ABCD_E678,2'd2,2'd2}, // R6
        '{2'd2,1'b0,1'b1,VA,RT,32'h0008_0001,32'hAAF3_78CF,1'b0,34'h2_ABCD_E678,2'd0,2'd2}, // R6
        '{2'd2,1'b1,1'b0,VA,RT,32'h0008_0001,32'hAAF3_78CF,1'b0,34'h2_ABCD_E678,2'd0,2'd2}, // R6
        '{2'd1,1'b1,1'b0,VA,RT,32'h0008_0001,32'hAAF3_78CF,1'b0,34'h0_ABCD_E678,2'd2,2'd2}, // R6
        '{2'd0,1'b1,1'b0,VA,RT,32'h5550_000B,32'h0000_0000,1'b0,34'h0_5574_5678,2'd1,2'd1}, // R5
        '{2'd0,1'b0,1'b0,VA,RT,32'h5550_000B,32'h0000_0000,1'b0,34'h1_5574_5678,2'd0,2'd1}, // R5
        '{2'd0,1'b1,1'b0,VA,RT,32'h5550_040B,32'h0000_0000,1'b1,34'h0,          2'd0,2'd1}, // R5
        '{2'd0,1'b1,1'b0,VA,RT,32'h0008_0000,32'h0000_0000,1'b1,34'h0,          2'd0,2'd1}, // R7
        '{2'd0,1'b1,1'b0,VA,RT,32'h0008_0005,32'h0000_0000,1'b1,34'h0,          2'd0,2'd1}, // R7
        '{2'd0,1'b1,1'b0,VA,RT,32'h0008_0001,32'h0008_0001,1'b1,34'h0,          2'd0,2'd2}, // R7
        '{2'd0,1'b1,1'b0,VA,RT,32'h0008_0001,32'hEAF3_78CF,1'b1,34'h0,          2'd0,2'd2}, // R8
        '{2'd0,1'b0,1'b0,VA,RT,32'h0008_0001,32'hEAF3_78CF,1'b0,34'h3_ABCD_E678,2'd0,2'd2}, // R8
        '{2'd0,1'b1,1'b0,VA,RT,32'h4008_0001,32'h0000_0000,1'b1,34'h0,          2'd0,2'd1}, // R8
        '{2'd0,1'b0,1'b0,VA,RT,32'h4008_0001,32'hAAF3_78CF,1'b0,34'h2_ABCD_E678,2'd0,2'd2}, // R8
        '{2'd3,1'b1,1'b1,VA,RT,32'h0008_0001,32'h6AF3_78CF,1'b0,34'h0_ABCD_E678,2'd1,2'd2}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_stage = '0;
    logic [21:0] req_root_ppn = '0;
    logic        menv_mt_en = 1'b0;
    logic        henv_mt_en = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic        done_fault;
    logic [33:0] done_paddr;
    logic [1:0]  done_mtype;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [33:0] cap_addr [2];
    int          cap_n = 0;
    logic [33:0] m_a1, m_a0;
    logic [31:0] m_d1, m_d0;
    bit          pend = 1'b0;
    logic [33:0] pend_addr = '0;

    always #2.5 clk = ~clk;

    sv32w_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_stage(req_stage), .req_root_ppn(req_root_ppn),
        .menv_mt_en(menv_mt_en), .henv_mt_en(henv_mt_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .done_fault(done_fault),
        .done_paddr(done_paddr), .done_mtype(done_mtype)
    );

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected<=100000", cycles);
            summary_and_end();
        end
    end

    // Memory model: one response the cycle after each accepted read.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = (pend_addr == m_a1) ? m_d1 :
                            (pend_addr == m_a0) ? m_d0 : 32'h0;
            pend = 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            pend = 1'b1;
            pend_addr = mem_req_addr;
            if (cap_n < 2) cap_addr[cap_n] = mem_req_addr;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [33:0] act,
                       input logic [33:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Runs one walk; entered and left on a falling edge.
    task automatic run_walk(input vec_t v);
        int  waits = 0;
        int  cyc = 0;
        bit  sid;
        m_a1 = {v.root, 12'h000} + 34'(v.va[31:22]) * 4;
        m_a0 = {v.pte1[31:10], 12'h000} + 34'(v.va[21:12]) * 4;
        m_d1 = v.pte1;
        m_d0 = v.pte0;
        sid = done;
        req_vaddr    = v.va;
        req_stage    = v.stage;
        req_root_ppn = v.root;
        menv_mt_en   = v.men;
        henv_mt_en   = v.hen;
        req_valid    = 1'b1;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
        end
        if (sid) chk(waits == 1, "R10 take-after-done", 34'(waits), 34'd1);
        cap_n = 0;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready-low-busy", 34'(req_ready), 34'd0);
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R9 done-seen", 34'(done), 34'd1);
        chk(cap_n == int'(v.nrd), "R2 read-count", 34'(cap_n), 34'(v.nrd));
        chk(cap_addr[0] == m_a1, "R2 root-addr", cap_addr[0], m_a1);
        if (v.nrd == 2'd2) chk(cap_addr[1] == m_a0, "R2 next-addr", cap_addr[1], m_a0);
        chk(done_fault == v.fault, "R7 R8 R5 fault", 34'(done_fault), 34'(v.fault));
        chk(done_paddr == v.pa, "R3 R4 R5 R6 paddr", done_paddr, v.pa);
        chk(done_mtype == v.mt, "R3 R4 R6 mtype", 34'(done_mtype), 34'(v.mt));
    endtask

    initial begin
        // R1: reset values.
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done", 34'(done), 34'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 34'(mem_req_valid), 34'd0);
        chk(req_ready == 1'b1, "R1 req_ready", 34'(req_ready), 34'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 idle-after-reset", 34'(req_ready), 34'd1);

        // Vector table; each walk starts in the done cycle of the one before (R10).
        for (int i = 0; i < NV; i++) begin
            if (i > 0) chk(req_ready == 1'b0, "R10 busy-during-done", 34'(req_ready), 34'd0);
            run_walk(VT[i]);
        end

        // R9: done lasts one cycle.
        @(negedge clk);
        chk(done == 1'b0, "R9 done-one-cycle", 34'(done), 34'd0);

        // R2: a stalled read holds its address.
        m_a1 = {RT, 12'h000} + 34'(VA[31:22]) * 4;
        mem_req_ready = 1'b0;
        req_vaddr = VA; req_root_ppn = RT; req_stage = 2'd0;
        menv_mt_en = 1'b1; henv_mt_en = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_req_valid == 1'b1, "R2 stall-valid", 34'(mem_req_valid), 34'd1);
        chk(mem_req_addr == m_a1, "R2 stall-addr", mem_req_addr, m_a1);
        mem_req_ready = 1'b1;
        repeat (8) @(negedge clk);
        chk(req_ready == 1'b1, "R9 back-idle", 34'(req_ready), 34'd1);

        summary_and_end();
    end
endmodule